// File: doc/BRIEF.md
# Single-Flag Predication Control Stage

This block sits at the register-fetch stage of an in-order pipeline and handles predication with a single flag bit. An issue group of up to `LANES` instructions arrives each cycle. Each instruction carries a 2-bit predicate mode and its write enables. Every instruction in the group is tested against the flag value that is current for that cycle. An instruction that passes enters execute with its enables unchanged. An instruction that fails still enters execute as a NOP: it keeps its valid bit and tag, and it loses every enable.

The architectural flag is written when a live compare leaves execute. The compare's result is also forwarded back to register fetch in the same cycle, so the next issue group tests against the new value without stalling. A flush discards the issue group and everything in execute. The flag keeps the value it last committed. Because all lanes of a group see the same flag value, an if-true instruction and an if-false instruction can issue side by side, and exactly one of the two takes effect.

Top module: `pred_issue_stage`

## Requirements
- R1: After reset, all execute-stage lanes read invalid with every enable low, and the committed flag reads 0.
- R2: A valid instruction whose mode field is 2'b00 (always) or 2'b11 (reserved, treated as always) reaches execute one cycle later with its register-write, memory-write and compare-write enables unchanged, and with its NOP marker low.
- R3: Mode 2'b01 (if-true) executes only when the flag seen at register fetch is 1. Mode 2'b10 (if-false) executes only when that flag is 0.
- R4: An instruction that fails its test still appears in execute one cycle later as valid, with its tag kept and its NOP marker high. Its register-write, memory-write and compare-write enables are all 0.
- R5: A valid, non-NOP compare in execute writes its `ex_cmp_result` into the committed flag at the next clock edge. When more than one lane holds such a compare, the highest-numbered lane wins. Without such a compare the flag holds its value.
- R6: In the same cycle, `rf_flag_seen` equals the result of the live compare in execute, or the committed flag when there is none. This value is the one that register-fetch predicates are tested against.
- R7: A compare that fails its predicate leaves the committed flag unchanged.
- R8: All lanes of one issue group test the same flag value. An if-true and an if-false instruction issued together produce exactly one executing instruction.
- R9: A flush makes every execute lane invalid at the next edge. A compare sitting in execute during a flush cycle does not change the committed flag.
- R10: An invalid register-fetch lane enters execute invalid, with tag 0 and all enables 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard the issue group and the execute stage |
| rf_valid | input | LANES | Lane holds an instruction at register fetch |
| rf_mode | input | 2*LANES | Predicate mode per lane (lane i at bits 2i+1:2i) |
| rf_reg_we | input | LANES | Register-write enable per lane |
| rf_mem_we | input | LANES | Memory-write enable per lane |
| rf_cmp_we | input | LANES | Lane is a compare that writes the flag |
| rf_tag | input | TAG_W*LANES | Instruction tag per lane |
| ex_cmp_result | input | LANES | Compare outcome from the ALU for each execute lane |
| rf_flag_seen | output | 1 | Flag value the register-fetch predicates are tested against |
| flag_q | output | 1 | Committed predicate flag |
| ex_valid | output | LANES | Execute lane occupied |
| ex_nop | output | LANES | Execute lane was squashed by its predicate |
| ex_reg_we | output | LANES | Gated register-write enable in execute |
| ex_mem_we | output | LANES | Gated memory-write enable in execute |
| ex_cmp_we | output | LANES | Gated compare-write enable in execute |
| ex_tag | output | TAG_W*LANES | Tag carried into execute |

## Verification
Some rules are checked by the embedded assertions on every cycle. A NOP lane or an empty lane never carries an enable. An opposite-sense pair always yields exactly one pass. A flush leaves the flag stable and empties execute. The flag changes only when a live compare commits, and the committed value equals the value that was forwarded. Other behaviour only shows up in the bench's scenarios. These include the polarity of each mode, the reserved code acting as always, the highest-lane priority among compares, and back-to-back compare-then-use groups that depend on forwarding. They also include a failed compare leaving the flag alone, each checked against a bench model of the flag and the execute stage.

// File: rtl/pred_pkg.sv
package pred_pkg;

  typedef enum logic [1:0] {
    PM_ALWAYS   = 2'b00,
    PM_IF_TRUE  = 2'b01,
    PM_IF_FALSE = 2'b10,
    PM_RSVD     = 2'b11
  } pmode_e;

  typedef struct packed {
    logic valid;
    logic nop;
    logic reg_we;
    logic mem_we;
    logic cmp_we;
  } lane_ctl_t;

  // Predicate test: reserved code behaves like always.
  function automatic logic pred_pass(input logic [1:0] mode, input logic flag);
    case (mode)
      PM_IF_TRUE:  pred_pass = flag;
      PM_IF_FALSE: pred_pass = ~flag;
      default:     pred_pass = 1'b1;
    endcase
  endfunction

  // Gate one lane's enables by its predicate outcome.
  function automatic lane_ctl_t gate_lane(input logic valid, input logic pass,
                                          input logic reg_we, input logic mem_we,
                                          input logic cmp_we);
    lane_ctl_t c;
    c.valid  = valid;
    c.nop    = valid & ~pass;
    c.reg_we = valid & pass & reg_we;
    c.mem_we = valid & pass & mem_we;
    c.cmp_we = valid & pass & cmp_we;
    return c;
  endfunction

endpackage

// File: rtl/pred_flag_unit.sv
module pred_flag_unit #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [LANES-1:0] ex_live_cmp,
  input  logic [LANES-1:0] ex_cmp_result,
  output logic             cmp_live,
  output logic             flag_fwd,
  output logic             flag_q
);

  logic fwd_val;

  // Highest-numbered live compare wins.
  always_comb begin
    cmp_live = 1'b0;
    fwd_val  = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (ex_live_cmp[i]) begin
        cmp_live = 1'b1;
        fwd_val  = ex_cmp_result[i];
      end
    end
  end

  assign flag_fwd = cmp_live ? fwd_val : flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag_q <= 1'b0;
    else if (!flush && cmp_live) flag_q <= fwd_val;
  end

  p_flush_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> $stable(flag_q));
  p_no_cmp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !cmp_live) |=> $stable(flag_q));
  p_commit_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && cmp_live) |=> (flag_q == $past(flag_fwd)));

endmodule

// File: rtl/pred_lane_gate.sv
module pred_lane_gate
  import pred_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] mode,
  input  logic       reg_we,
  input  logic       mem_we,
  input  logic       cmp_we,
  input  logic       flag,
  output logic       pass,
  output lane_ctl_t  ctl
);

  assign pass = pred_pass(mode, flag);
  assign ctl  = gate_lane(valid, pass, reg_we, mem_we, cmp_we);

endmodule

// File: rtl/pred_ex_reg.sv
module pred_ex_reg
  import pred_pkg::*;
#(
  parameter int LANES = 2,
  parameter int TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  lane_ctl_t [LANES-1:0]  ctl_d,
  input  logic [LANES*TAG_W-1:0] tag_d,
  output lane_ctl_t [LANES-1:0]  ctl_q,
  output logic [LANES*TAG_W-1:0] tag_q
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q[g]                  <= '0;
        tag_q[g*TAG_W +: TAG_W]   <= '0;
      end else if (flush || !ctl_d[g].valid) begin
        ctl_q[g]                  <= '0;
        tag_q[g*TAG_W +: TAG_W]   <= '0;
      end else begin
        ctl_q[g]                  <= ctl_d[g];
        tag_q[g*TAG_W +: TAG_W]   <= tag_d[g*TAG_W +: TAG_W];
      end
    end

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !ctl_q[g].valid);
  end

endmodule

// File: rtl/pred_issue_stage.sv
module pred_issue_stage
  import pred_pkg::*;
#(
  parameter int LANES = 2,
  parameter int TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [LANES-1:0]       rf_valid,
  input  logic [2*LANES-1:0]     rf_mode,
  input  logic [LANES-1:0]       rf_reg_we,
  input  logic [LANES-1:0]       rf_mem_we,
  input  logic [LANES-1:0]       rf_cmp_we,
  input  logic [LANES*TAG_W-1:0] rf_tag,
  input  logic [LANES-1:0]       ex_cmp_result,
  output logic                   rf_flag_seen,
  output logic                   flag_q,
  output logic [LANES-1:0]       ex_valid,
  output logic [LANES-1:0]       ex_nop,
  output logic [LANES-1:0]       ex_reg_we,
  output logic [LANES-1:0]       ex_mem_we,
  output logic [LANES-1:0]       ex_cmp_we,
  output logic [LANES*TAG_W-1:0] ex_tag
);

  lane_ctl_t [LANES-1:0] rf_ctl;
  lane_ctl_t [LANES-1:0] ex_ctl;
  logic [LANES-1:0]      lane_pass;
  logic [LANES-1:0]      ex_live_cmp;
  logic                  cmp_live;

  for (genvar g = 0; g < LANES; g++) begin : g_gate
    pred_lane_gate u_gate (
      .valid  (rf_valid[g]),
      .mode   (rf_mode[2*g +: 2]),
      .reg_we (rf_reg_we[g]),
      .mem_we (rf_mem_we[g]),
      .cmp_we (rf_cmp_we[g]),
      .flag   (rf_flag_seen),
      .pass   (lane_pass[g]),
      .ctl    (rf_ctl[g])
    );

    assign ex_valid[g]    = ex_ctl[g].valid;
    assign ex_nop[g]      = ex_ctl[g].nop;
    assign ex_reg_we[g]   = ex_ctl[g].reg_we;
    assign ex_mem_we[g]   = ex_ctl[g].mem_we;
    assign ex_cmp_we[g]   = ex_ctl[g].cmp_we;
    assign ex_live_cmp[g] = ex_ctl[g].cmp_we;

    p_nop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ex_nop[g] |-> (ex_valid[g] && !ex_reg_we[g] && !ex_mem_we[g] && !ex_cmp_we[g]));
    p_empty_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_valid[g] |-> (!ex_nop[g] && !ex_reg_we[g] && !ex_mem_we[g] && !ex_cmp_we[g]
                        && ex_tag[g*TAG_W +: TAG_W] == '0));
  end

  pred_flag_unit #(.LANES(LANES)) u_flag (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .ex_live_cmp   (ex_live_cmp),
    .ex_cmp_result (ex_cmp_result),
    .cmp_live      (cmp_live),
    .flag_fwd      (rf_flag_seen),
    .flag_q        (flag_q)
  );

  pred_ex_reg #(.LANES(LANES), .TAG_W(TAG_W)) u_exr (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .ctl_d (rf_ctl),
    .tag_d (rf_tag),
    .ctl_q (ex_ctl),
    .tag_q (ex_tag)
  );

  if (LANES >= 2) begin : g_pair_chk
    p_pair_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_valid[1:0] == 2'b11 &&
       ((rf_mode[1:0] == PM_IF_TRUE  && rf_mode[3:2] == PM_IF_FALSE) ||
        (rf_mode[1:0] == PM_IF_FALSE && rf_mode[3:2] == PM_IF_TRUE)))
      |-> ($countones(lane_pass[1:0]) == 1));
  end

endmodule

// File: tb/pred_issue_stage_tb.sv
`timescale 1ns/1ps
module pred_issue_stage_tb;
  localparam int L = 2;
  localparam int TW = 8;

  logic clk = 0, rst_n = 0, flush = 0;
  logic [L-1:0] rf_valid = '0, rf_reg_we = '0, rf_mem_we = '0, rf_cmp_we = '0, ex_cmp_result = '0;
  logic [2*L-1:0] rf_mode = '0;
  logic [L*TW-1:0] rf_tag = '0;
  logic rf_flag_seen, flag_q;
  logic [L-1:0] ex_valid, ex_nop, ex_reg_we, ex_mem_we, ex_cmp_we;
  logic [L*TW-1:0] ex_tag;

  always #2.5 clk = ~clk;

  pred_issue_stage #(.LANES(L), .TAG_W(TW)) u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of execute stage and flag
  logic m_flag = 0;
  logic [L-1:0] m_v = '0, m_n = '0, m_r = '0, m_m = '0, m_c = '0;
  logic [L*TW-1:0] m_t = '0;
  string m_req [L];

  function automatic bit mpass(input logic [1:0] md, input logic f);
    if (md == 2'b01) return f == 1'b1;
    if (md == 2'b10) return f == 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic m_seen(output bit live);
    logic s = m_flag;
    live = 0;
    for (int i = 0; i < L; i++) if (m_v[i] && m_c[i]) begin live = 1; s = ex_cmp_result[i]; end
    return s;
  endfunction

  task automatic check_ex(input string tagflag);
    for (int i = 0; i < L; i++) begin
      chk({m_req[i], " lane"}, {27'd0, ex_valid[i], ex_nop[i], ex_reg_we[i], ex_mem_we[i], ex_cmp_we[i]},
          {27'd0, m_v[i], m_n[i], m_r[i], m_m[i], m_c[i]});
      chk({m_req[i], " tag"}, ex_tag[i*TW +: TW], m_t[i*TW +: TW]);
    end
    chk(tagflag, flag_q, m_flag);
  endtask

  // One cycle: check registered state, drive inputs, check forwarded flag, update model.
  task automatic step(input logic fl, input logic [L-1:0] v, input logic [2*L-1:0] md,
                      input logic [L-1:0] rw, input logic [L-1:0] mw, input logic [L-1:0] cw,
                      input logic [L*TW-1:0] tg, input logic [L-1:0] cr, input string flagreq);
    bit live; logic s; bit pairop;
    @(negedge clk);
    check_ex(flagreq);
    flush = fl; rf_valid = v; rf_mode = md; rf_reg_we = rw; rf_mem_we = mw;
    rf_cmp_we = cw; rf_tag = tg; ex_cmp_result = cr;
    #1;
    s = m_seen(live);
    chk(live ? "R6 forwarded flag" : "R6 committed flag", rf_flag_seen, s);
    pairop = (v == 2'b11) && ((md == 4'b1001) || (md == 4'b0110));
    @(posedge clk);
    if (!fl && live) m_flag = s;
    for (int i = 0; i < L; i++) begin
      bit p = mpass(md[2*i +: 2], s);
      if (fl || !v[i]) begin
        m_v[i] = 0; m_n[i] = 0; m_r[i] = 0; m_m[i] = 0; m_c[i] = 0; m_t[i*TW +: TW] = '0;
        m_req[i] = fl ? "R9" : "R10";
      end else begin
        m_v[i] = 1; m_n[i] = !p; m_r[i] = p & rw[i]; m_m[i] = p & mw[i]; m_c[i] = p & cw[i];
        m_t[i*TW +: TW] = tg[i*TW +: TW];
        m_req[i] = pairop ? "R8" : !p ? (cw[i] ? "R7" : "R4") :
                   (md[2*i +: 2] == 2'b01 || md[2*i +: 2] == 2'b10) ? "R3" : "R2";
      end
    end
  endtask

  initial begin
    int n = 0;
    repeat (40000) begin @(posedge clk); if (done) break; n++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240326));
    for (int i = 0; i < L; i++) m_req[i] = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_ex("R1 flag");  // reset state
    rst_n = 1;
    // R6: compare sets flag 1, next group if-true runs using forwarded value
    step(0, 2'b01, 4'b0000, 2'b00, 2'b00, 2'b01, 16'h0011, 2'b00, "R1");
    step(0, 2'b01, 4'b0001, 2'b01, 2'b00, 2'b00, 16'h0012, 2'b01, "R5");
    // R8: opposite pair with flag 1, then with flag 0 after a compare
    step(0, 2'b11, 4'b1001, 2'b11, 2'b11, 2'b00, 16'h1413, 2'b00, "R5");
    // R7: failing predicated compare (if-false while flag 1) must not touch flag
    step(0, 2'b01, 4'b0010, 2'b00, 2'b00, 2'b01, 16'h0015, 2'b00, "R5");
    step(0, 2'b00, 4'b0000, 2'b00, 2'b00, 2'b00, 16'h0000, 2'b00, "R7");
    // R5: two live compares, lane 1 wins (lane0 result 1, lane1 result 0)
    step(0, 2'b11, 4'b1100, 2'b00, 2'b00, 2'b11, 16'h1716, 2'b00, "R5");
    step(0, 2'b11, 4'b0110, 2'b11, 2'b00, 2'b00, 16'h1918, 2'b01, "R5");
    step(0, 2'b00, 4'b0000, 2'b00, 2'b00, 2'b00, 16'h0000, 2'b00, "R5");
    // R9: compare in execute during flush does not commit
    step(0, 2'b01, 4'b0000, 2'b00, 2'b00, 2'b01, 16'h0020, 2'b00, "R5");
    step(1, 2'b11, 4'b0000, 2'b11, 2'b11, 2'b00, 16'h2221, 2'b01, "R5");
    step(0, 2'b00, 4'b0000, 2'b00, 2'b00, 2'b00, 16'h0000, 2'b00, "R9");
    // random mix
    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 40) == 0, L'($urandom), (2*L)'($urandom), L'($urandom), L'($urandom),
           L'($urandom), (L*TW)'($urandom), L'($urandom), "R5");
    end
    step(0, '0, '0, '0, '0, '0, '0, '0, "R5");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule